// File: doc/BRIEF.md
# Two-Sided Doorbell Mailbox

This block sits between a host port and a management-controller port and gives each side a one-byte mailbox toward the other. The controller posts a byte for the host in the outbound slot. The host posts a byte for the controller in the inbound slot. Each slot has a full flag that hardware sets on a write and clears when the receiving side reads the byte. Both sides see one shared status byte. It combines the two full flags and a command/data marker, which only hardware updates, with five bits that controller software owns and uses to announce its own state and the channel state.

Each side has a simple synchronous register port: a request strobe, a write enable, one select bit and a byte of write data. Read data is combinational from the stored registers. The side effects of an access (flag clears, interrupt clears) take place at the clock edge that ends the access cycle. There is one level interrupt per side. The controller interrupt follows the inbound full flag. The host interrupt is raised by an outbound byte write or by a status write from the controller.

Top module: `dbell_mailbox`

## Requirements
- R1: After reset both data bytes, the status byte and both interrupts are zero.
- R2: A controller data write (c_sel=0) stores the byte that a host data read (h_sel=0) returns. From the next cycle it sets status bit 0 (outbound full) and drives h_irq high.
- R3: A host data read clears status bit 0 from the next cycle. With no status write pending, h_irq then drops.
- R4: A host write stores the byte that a controller data read (c_sel=0) returns. From the next cycle it sets status bit 1 (inbound full) and drives c_irq high.
- R5: A controller data read clears status bit 1 and c_irq from the next cycle.
- R6: Status bit 3 becomes 1 after a host write with h_sel=1 (command address) and 0 after a host write with h_sel=0 (data address). Other accesses leave it unchanged.
- R7: A controller status write (c_sel=1) loads bits 7, 6, 5, 4 and 2 from c_wdata and leaves bits 0, 1 and 3 unchanged. Both sides read the same status byte: host with h_sel=1, controller with c_sel=1.
- R8: A controller status write drives h_irq high from the next cycle. A later host status read clears that cause, so h_irq stays high afterwards only while status bit 0 is set.
- R9: A data write into a slot whose full flag is already set replaces the byte and leaves the flag set.
- R10: When a slot is written and its clearing read happens in the same cycle, the read returns the old byte and the flag stays set with the new byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_req | input | 1 | Host access strobe |
| h_we | input | 1 | Host write (1) or read (0) |
| h_sel | input | 1 | Host select: 0 data, 1 command on write or status on read |
| h_wdata | input | 8 | Host write byte |
| h_rdata | output | 8 | Host read byte: outbound data or status |
| h_irq | output | 1 | Host interrupt |
| c_req | input | 1 | Controller access strobe |
| c_we | input | 1 | Controller write (1) or read (0) |
| c_sel | input | 1 | Controller select: 0 data, 1 status |
| c_wdata | input | 8 | Controller write byte |
| c_rdata | output | 8 | Controller read byte: inbound data or status |
| c_irq | output | 1 | Controller interrupt |

## Verification
A wrong full flag shows up in the status byte one cycle after the access that should have changed it. It also shows at once on the interrupt line that follows it, so a missed set or clear surfaces in the very next controller status read. A corrupted software bit or command/data marker stays wrong until the next write to it, so the status reads after mixed host and controller traffic expose it. Same-cycle write/read collisions and overwrites of full slots are driven on purpose, because a wrong priority there loses a doorbell without any other symptom.

// File: rtl/dbell_pkg.sv
package dbell_pkg;

    localparam int DW = 8;
    localparam int N_SLOT = 2;
    localparam int SLOT_OUT = 0;   // controller -> host
    localparam int SLOT_IN  = 1;   // host -> controller

    localparam int B_OUT_FULL = 0;
    localparam int B_IN_FULL  = 1;
    localparam int B_CMD      = 3;

    localparam logic [DW-1:0] HW_MASK =
        (DW'(1) << B_OUT_FULL) | (DW'(1) << B_IN_FULL) | (DW'(1) << B_CMD);
    localparam logic [DW-1:0] SW_MASK = ~HW_MASK;

    typedef struct packed {
        logic          req;
        logic          we;
        logic          sel;
        logic [DW-1:0] wdata;
    } port_req_t;

    typedef struct packed {
        logic wr_data;
        logic wr_alt;
        logic rd_data;
        logic rd_stat;
    } port_op_t;

    function automatic port_op_t decode(port_req_t r);
        port_op_t o;
        o.wr_data = r.req &  r.we & ~r.sel;
        o.wr_alt  = r.req &  r.we &  r.sel;
        o.rd_data = r.req & ~r.we & ~r.sel;
        o.rd_stat = r.req & ~r.we &  r.sel;
        return o;
    endfunction

    function automatic logic [DW-1:0] pack_status(logic [DW-1:0] sw,
                                                  logic out_full,
                                                  logic in_full,
                                                  logic cmd);
        logic [DW-1:0] s;
        s = sw & SW_MASK;
        s[B_OUT_FULL] = out_full;
        s[B_IN_FULL]  = in_full;
        s[B_CMD]      = cmd;
        return s;
    endfunction

endpackage

// File: rtl/dbell_slot.sv
module dbell_slot #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] data_q,
    output logic         full_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            full_q <= 1'b0;
        end else begin
            if (wr_en) data_q <= wr_data;
            // a write in the same cycle as the clearing read wins
            if (wr_en)      full_q <= 1'b1;
            else if (rd_en) full_q <= 1'b0;
        end
    end
endmodule

// File: rtl/dbell_stat.sv
module dbell_stat
    import dbell_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          sw_wr,
    input  logic [DW-1:0] sw_data,
    input  logic          host_wr,
    input  logic          host_cmd,
    input  logic          host_stat_rd,
    output logic [DW-1:0] sw_q,
    output logic          cmd_q,
    output logic          pend_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sw_q   <= '0;
            cmd_q  <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            if (sw_wr)   sw_q  <= sw_data & SW_MASK;
            if (host_wr) cmd_q <= host_cmd;
            if (sw_wr)             pend_q <= 1'b1;
            else if (host_stat_rd) pend_q <= 1'b0;
        end
    end
endmodule

// File: rtl/dbell_mailbox.sv
module dbell_mailbox
    import dbell_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          h_req,
    input  logic          h_we,
    input  logic          h_sel,
    input  logic [DW-1:0] h_wdata,
    output logic [DW-1:0] h_rdata,
    output logic          h_irq,
    input  logic          c_req,
    input  logic          c_we,
    input  logic          c_sel,
    input  logic [DW-1:0] c_wdata,
    output logic [DW-1:0] c_rdata,
    output logic          c_irq
);
    port_req_t h_r, c_r;
    port_op_t  h_op, c_op;

    assign h_r  = '{req: h_req, we: h_we, sel: h_sel, wdata: h_wdata};
    assign c_r  = '{req: c_req, we: c_we, sel: c_sel, wdata: c_wdata};
    assign h_op = decode(h_r);
    assign c_op = decode(c_r);

    logic          slot_wr   [N_SLOT];
    logic          slot_rd   [N_SLOT];
    logic [DW-1:0] slot_wd   [N_SLOT];
    logic [DW-1:0] slot_q    [N_SLOT];
    logic          slot_full [N_SLOT];

    // outbound: controller writes, host reads
    assign slot_wr[SLOT_OUT] = c_op.wr_data;
    assign slot_wd[SLOT_OUT] = c_wdata;
    assign slot_rd[SLOT_OUT] = h_op.rd_data;
    // inbound: host writes via either address, controller reads
    assign slot_wr[SLOT_IN]  = h_op.wr_data | h_op.wr_alt;
    assign slot_wd[SLOT_IN]  = h_wdata;
    assign slot_rd[SLOT_IN]  = c_op.rd_data;

    for (genvar i = 0; i < N_SLOT; i++) begin : g_slot
        dbell_slot #(.W(DW)) slot_i (
            .clk    (clk),
            .rst    (rst),
            .wr_en  (slot_wr[i]),
            .wr_data(slot_wd[i]),
            .rd_en  (slot_rd[i]),
            .data_q (slot_q[i]),
            .full_q (slot_full[i])
        );
    end

    logic [DW-1:0] sw_q;
    logic          cmd_q, pend_q;

    dbell_stat stat_i (
        .clk         (clk),
        .rst         (rst),
        .sw_wr       (c_op.wr_alt),
        .sw_data     (c_wdata),
        .host_wr     (slot_wr[SLOT_IN]),
        .host_cmd    (h_sel),
        .host_stat_rd(h_op.rd_stat),
        .sw_q        (sw_q),
        .cmd_q       (cmd_q),
        .pend_q      (pend_q)
    );

    logic [DW-1:0] stat_w;
    assign stat_w  = pack_status(sw_q, slot_full[SLOT_OUT], slot_full[SLOT_IN], cmd_q);

    assign h_rdata = h_sel ? stat_w : slot_q[SLOT_OUT];
    assign c_rdata = c_sel ? stat_w : slot_q[SLOT_IN];
    assign h_irq   = slot_full[SLOT_OUT] | pend_q;
    assign c_irq   = slot_full[SLOT_IN];
endmodule

// File: rtl/dbell_mailbox_chk.sv
module dbell_mailbox_chk (
    input logic       clk,
    input logic       rst,
    input logic       h_req,
    input logic       h_we,
    input logic       h_sel,
    input logic       c_req,
    input logic       c_we,
    input logic       c_sel,
    input logic [7:0] c_wdata,
    input logic [7:0] stat,
    input logic       h_irq,
    input logic       c_irq
);
    logic h_wr, h_rd_d, h_rd_s, c_wr_d, c_wr_s, c_rd_d;
    assign h_wr   = h_req & h_we;
    assign h_rd_d = h_req & ~h_we & ~h_sel;
    assign h_rd_s = h_req & ~h_we &  h_sel;
    assign c_wr_d = c_req & c_we & ~c_sel;
    assign c_wr_s = c_req & c_we &  c_sel;
    assign c_rd_d = c_req & ~c_we & ~c_sel;

    assert_out_set_R2: assert property (@(posedge clk) disable iff (rst)
        c_wr_d |=> stat[0] && h_irq);
    assert_out_clr_R3: assert property (@(posedge clk) disable iff (rst)
        (h_rd_d && !c_wr_d) |=> !stat[0]);
    assert_in_set_R4: assert property (@(posedge clk) disable iff (rst)
        h_wr |=> stat[1] && c_irq);
    assert_in_clr_R5: assert property (@(posedge clk) disable iff (rst)
        (c_rd_d && !h_wr) |=> !stat[1] && !c_irq);
    assert_cmd_bit_R6: assert property (@(posedge clk) disable iff (rst)
        h_wr |=> stat[3] == $past(h_sel));
    assert_sw_bits_R7: assert property (@(posedge clk) disable iff (rst)
        c_wr_s |=> (stat & 8'hF4) == ($past(c_wdata) & 8'hF4));
    assert_hw_bits_R7: assert property (@(posedge clk) disable iff (rst)
        (!h_wr && !c_wr_d && !h_rd_d && !c_rd_d) |=> (stat & 8'h0B) == $past(stat & 8'h0B));
    assert_stat_irq_R8: assert property (@(posedge clk) disable iff (rst)
        c_wr_s |=> h_irq);
    assert_stat_ack_R8: assert property (@(posedge clk) disable iff (rst)
        (h_rd_s && !c_wr_s && !c_wr_d && !stat[0]) |=> !h_irq);
    assert_collide_R10: assert property (@(posedge clk) disable iff (rst)
        (c_wr_d && h_rd_d) |=> stat[0]);
endmodule

bind dbell_mailbox dbell_mailbox_chk chk_i (
    .clk    (clk),
    .rst    (rst),
    .h_req  (h_req),
    .h_we   (h_we),
    .h_sel  (h_sel),
    .c_req  (c_req),
    .c_we   (c_we),
    .c_sel  (c_sel),
    .c_wdata(c_wdata),
    .stat   (stat_w),
    .h_irq  (h_irq),
    .c_irq  (c_irq)
);

// File: tb/dbell_mailbox_tb_top.sv
module dbell_mailbox_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       h_req = 0, h_we = 0, h_sel = 0;
    logic [7:0] h_wdata = 0;
    logic [7:0] h_rdata;
    logic       h_irq;
    logic       c_req = 0, c_we = 0, c_sel = 0;
    logic [7:0] c_wdata = 0;
    logic [7:0] c_rdata;
    logic       c_irq;

    always #10 clk = ~clk;   // 50 MHz

    dbell_mailbox dut_i (
        .clk(clk), .rst(rst),
        .h_req(h_req), .h_we(h_we), .h_sel(h_sel), .h_wdata(h_wdata),
        .h_rdata(h_rdata), .h_irq(h_irq),
        .c_req(c_req), .c_we(c_we), .c_sel(c_sel), .c_wdata(c_wdata),
        .c_rdata(c_rdata), .c_irq(c_irq)
    );

    // kind: 0 host read byte, 1 controller read byte, 2 h_irq, 3 c_irq
    typedef struct {
        int         kind;
        logic [7:0] exp;
        string      req;
    } item_t;

    item_t q[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    task automatic expect_item(input int kind, input logic [7:0] exp, input string req);
        item_t it;
        it.kind = kind; it.exp = exp; it.req = req;
        q.push_back(it);
    endtask

    // one access cycle: inputs set after the falling edge, held through the rising edge
    task automatic drive(input logic hr, input logic hw, input logic hs, input logic [7:0] hd,
                         input logic cr, input logic cw, input logic cs, input logic [7:0] cd);
        @(negedge clk);
        h_req = hr; h_we = hw; h_sel = hs; h_wdata = hd;
        c_req = cr; c_we = cw; c_sel = cs; c_wdata = cd;
    endtask

    task automatic c_stat(input logic [7:0] e, input string req);
        drive(0,0,0,0, 1,0,1,0);
        expect_item(1, e, req);
    endtask

    // monitor: compares queued expectations mid-cycle
    initial begin
        forever begin
            @(negedge clk);
            #5;
            while (q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = q.pop_front();
                case (it.kind)
                    0: act = h_rdata;
                    1: act = c_rdata;
                    2: act = {7'd0, h_irq};
                    default: act = {7'd0, c_irq};
                endcase
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s kind=%0d actual=%02h expected=%02h",
                             it.req, it.kind, act, it.exp);
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < 5000; i++) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;

        // R1: reset state
        drive(1,0,0,0, 1,0,1,0);
        expect_item(0, 8'h00, "R1");
        expect_item(1, 8'h00, "R1");
        expect_item(2, 0, "R1");
        expect_item(3, 0, "R1");

        // R2: controller posts outbound byte
        drive(0,0,0,0, 1,1,0,8'hA5);
        expect_item(2, 0, "R2");
        c_stat(8'h01, "R2");
        expect_item(2, 1, "R2");
        drive(1,0,0,0, 1,0,1,0);
        expect_item(0, 8'hA5, "R2");
        expect_item(1, 8'h01, "R2");
        // R3: host read cleared it
        c_stat(8'h00, "R3");
        expect_item(2, 0, "R3");

        // R4/R6: host writes through command address
        drive(1,1,1,8'h01, 0,0,0,0);
        c_stat(8'h0A, "R4_R6");
        expect_item(3, 1, "R4");
        drive(0,0,0,0, 1,0,0,0);
        expect_item(1, 8'h01, "R4");
        c_stat(8'h08, "R5");
        expect_item(3, 0, "R5");

        // R6: data address clears command marker
        drive(1,1,0,8'h77, 0,0,0,0);
        c_stat(8'h02, "R6");
        drive(0,0,0,0, 1,0,0,0);
        expect_item(1, 8'h77, "R4");
        c_stat(8'h00, "R5");

        // R7/R8: status write
        drive(0,0,0,0, 1,1,1,8'hFF);
        drive(1,0,1,0, 1,0,1,0);
        expect_item(0, 8'hF4, "R7");
        expect_item(1, 8'hF4, "R7");
        expect_item(2, 1, "R8");
        c_stat(8'hF4, "R7");
        expect_item(2, 0, "R8");

        // R7: status write with all hardware bits set
        drive(0,0,0,0, 1,1,0,8'h11);
        drive(1,1,1,8'h22, 0,0,0,0);
        drive(0,0,0,0, 1,1,1,8'hC0);
        c_stat(8'hCB, "R7");
        expect_item(2, 1, "R8");
        drive(1,0,1,0, 0,0,0,0);
        expect_item(0, 8'hCB, "R7");
        // R8: pending cleared, outbound still full keeps h_irq
        drive(0,0,0,0, 1,1,0,8'h33);
        expect_item(2, 1, "R8");

        // R9: overwrite full slots
        drive(1,1,0,8'h44, 1,0,1,0);
        expect_item(1, 8'hCB, "R9");
        drive(1,0,0,0, 1,0,1,0);
        expect_item(0, 8'h33, "R9");
        expect_item(1, 8'hC3, "R9");
        drive(0,0,0,0, 1,0,0,0);
        expect_item(1, 8'h44, "R9");
        c_stat(8'hC0, "R9");
        expect_item(2, 0, "R3");
        expect_item(3, 0, "R5");

        // R10: outbound write collides with host read
        drive(1,0,0,0, 1,1,0,8'h55);
        expect_item(0, 8'h33, "R10");
        drive(1,0,0,0, 1,0,1,0);
        expect_item(1, 8'hC1, "R10");
        expect_item(0, 8'h55, "R10");
        c_stat(8'hC0, "R10");
        expect_item(2, 0, "R10");

        // R10: inbound write collides with controller read
        drive(1,1,0,8'h66, 0,0,0,0);
        drive(1,1,0,8'h67, 1,0,0,0);
        expect_item(1, 8'h66, "R10");
        drive(0,0,0,0, 1,0,1,0);
        expect_item(1, 8'hC2, "R10");
        expect_item(3, 1, "R10");
        drive(0,0,0,0, 1,0,0,0);
        expect_item(1, 8'h67, "R10");
        c_stat(8'hC0, "R5");

        drive(0,0,0,0, 0,0,0,0);
        @(negedge clk);
        #8;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule